// File: doc/BRIEF.md
# Stereo Sample-Rate Converter FIFO

This block is the two-channel sample store that sits between the input-rate side of an asynchronous sample-rate converter and its interpolation stage. Each input frame strobe writes one left and one right sample at a shared write pointer. The write pointer starts a fixed guard distance ahead of the read pointer. The interpolation stage moves a read pointer forward by whatever step its ratio tracking computes. It then requests individual taps of a filter window that extends forward from that read pointer.

Each tap request is checked against the fill level, which is the modulo distance from the read pointer to the write pointer. A tap whose window position would come within the guard band of the write address is not served as asked. The read is redirected to the newest word that is still safe to read. That response is marked, and a sticky overlap flag is raised. The guard size and the filter window length are fixed by parameters. Together with the depth they set the largest usable decimation ratio, (depth − guard) / taps, which is 7.75 with the default values.

Top module: `src_stereo_fifo`

## Requirements
- R1: A synchronous reset clears the read pointer to 0, loads the write pointer with the guard value (16), and clears `rd_valid`, `rd_clamp` and `overlap`. A tap-0 read right after reset is therefore clamped to address 511.
- R2: When `wr_en` is high, `wr_left` and `wr_right` are stored at the current write address, and the write pointer then advances by one.
- R3: A read of tap t is legal when t + 16 < room, where room = (write pointer − read pointer) mod 512. A legal read uses address (read pointer + t) mod 512.
- R4: A read that is not legal is served from address (write pointer − 17) mod 512, and `rd_clamp` is 1 with that response. A legal read returns `rd_clamp` = 0.
- R5: `overlap` rises with the first clamped response and stays at 1 until reset, even if later reads are legal.
- R6: The response appears exactly one cycle after `rd_req`. In that cycle `rd_valid` = 1, and `rd_left` and `rd_right` hold the samples stored at `rd_addr`. `rd_valid` is 0 in a cycle that follows no request.
- R7: When `rd_adv` is high, `rd_step` is added to the read pointer modulo 512.
- R8: Both pointers and the tap address wrap modulo 512. Data written across the wrap is read back at the wrapped addresses.
- R9: A read is judged against the pointer values from before any write or advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Input frame strobe, writes both channels |
| wr_left | input | DW (24) | Left sample to store |
| wr_right | input | DW (24) | Right sample to store |
| rd_adv | input | 1 | Advance the read pointer |
| rd_step | input | log2(DEPTH) (9) | Read pointer increment |
| rd_req | input | 1 | Tap read request |
| rd_tap | input | log2(TAPS) (6) | Tap index forward of the read pointer |
| rd_valid | output | 1 | Read response valid |
| rd_addr | output | log2(DEPTH) (9) | Address actually read |
| rd_left | output | DW (24) | Left sample read |
| rd_right | output | DW (24) | Right sample read |
| rd_clamp | output | 1 | This response was redirected into the safe area |
| overlap | output | 1 | Sticky: some read reached the guard band |

## Verification
Every read result (`rd_valid`, `rd_addr`, `rd_clamp`, the samples and the rising edge of `overlap`) is due one cycle after the request. Pointer updates from a write or an advance take effect for the next request, never for a request in the same cycle. The bench drives each stimulus just after a falling edge. It lets one rising edge capture that stimulus and compares outputs at the following falling edge, so each result is read in exactly the cycle it is due. The same-cycle cases are built so that the room limit sits exactly at the boundary, where using the pointer values from after the write or advance would flip the result between legal and clamped.

// File: rtl/srcf_pkg.sv
package srcf_pkg;
  localparam int unsigned DEF_DEPTH = 512;
  localparam int unsigned DEF_DW    = 24;
  localparam int unsigned DEF_GUARD = 16;
  localparam int unsigned DEF_TAPS  = 64;

  localparam int NUM_CH = 2;
  localparam int CH_L   = 0;
  localparam int CH_R   = 1;
endpackage

// File: rtl/srcf_ptrs.sv
module srcf_ptrs #(
  parameter int unsigned AW    = 9,
  parameter int unsigned GUARD = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          adv_en,
  input  logic [AW-1:0] adv_step,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr
);
  localparam logic [AW-1:0] WR_START = AW'(GUARD);

  // power-of-two depth: wrap comes from the pointer width
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= WR_START;
      rd_ptr <= '0;
    end else begin
      if (wr_en)  wr_ptr <= wr_ptr + 1'b1;
      if (adv_en) rd_ptr <= rd_ptr + adv_step;
    end
  end
endmodule

// File: rtl/srcf_guard.sv
module srcf_guard #(
  parameter int unsigned AW    = 9,
  parameter int unsigned TW    = 6,
  parameter int unsigned GUARD = 16
) (
  input  logic [AW-1:0] wr_ptr,
  input  logic [AW-1:0] rd_ptr,
  input  logic [TW-1:0] tap,
  output logic [AW-1:0] addr,
  output logic          clamp
);
  localparam logic [AW:0]   GUARD_W = (AW+1)'(GUARD);
  localparam logic [AW-1:0] BACKOFF = AW'(GUARD + 1);

  logic [AW-1:0] room;
  logic [AW:0]   need;

  always_comb begin
    room  = wr_ptr - rd_ptr;
    need  = (AW+1)'(tap) + GUARD_W;
    clamp = !(need < {1'b0, room});
    addr  = clamp ? (wr_ptr - BACKOFF) : (rd_ptr + AW'(tap));
  end
endmodule

// File: rtl/srcf_ram.sv
module srcf_ram #(
  parameter int unsigned AW = 9,
  parameter int unsigned DW = 24
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  // simple dual port, registered read, no reset on data: block RAM shape
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/src_stereo_fifo.sv
module src_stereo_fifo
  import srcf_pkg::*;
#(
  parameter int unsigned DEPTH = DEF_DEPTH,
  parameter int unsigned DW    = DEF_DW,
  parameter int unsigned GUARD = DEF_GUARD,
  parameter int unsigned TAPS  = DEF_TAPS
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [DW-1:0]            wr_left,
  input  logic [DW-1:0]            wr_right,
  input  logic                     rd_adv,
  input  logic [$clog2(DEPTH)-1:0] rd_step,
  input  logic                     rd_req,
  input  logic [$clog2(TAPS)-1:0]  rd_tap,
  output logic                     rd_valid,
  output logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [DW-1:0]            rd_left,
  output logic [DW-1:0]            rd_right,
  output logic                     rd_clamp,
  output logic                     overlap
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned TW = $clog2(TAPS);

  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [AW-1:0] cand_addr;
  logic          cand_clamp;

  logic [NUM_CH-1:0][DW-1:0] ch_wdata;
  logic [NUM_CH-1:0][DW-1:0] ch_rdata;

  srcf_ptrs #(.AW(AW), .GUARD(GUARD)) u_ptrs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .adv_en   (rd_adv),
    .adv_step (rd_step),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr)
  );

  // judged on this cycle's pointers, before any write or advance lands
  srcf_guard #(.AW(AW), .TW(TW), .GUARD(GUARD)) u_guard (
    .wr_ptr (wr_ptr),
    .rd_ptr (rd_ptr),
    .tap    (rd_tap),
    .addr   (cand_addr),
    .clamp  (cand_clamp)
  );

  assign ch_wdata[CH_L] = wr_left;
  assign ch_wdata[CH_R] = wr_right;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    srcf_ram #(.AW(AW), .DW(DW)) u_ram (
      .clk   (clk),
      .we    (wr_en),
      .waddr (wr_ptr),
      .wdata (ch_wdata[c]),
      .re    (rd_req),
      .raddr (cand_addr),
      .rdata (ch_rdata[c])
    );
  end

  assign rd_left  = ch_rdata[CH_L];
  assign rd_right = ch_rdata[CH_R];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_addr  <= '0;
      rd_clamp <= 1'b0;
      overlap  <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) begin
        rd_addr  <= cand_addr;
        rd_clamp <= cand_clamp;
        if (cand_clamp) overlap <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/src_stereo_fifo_chk.sv
module src_stereo_fifo_chk #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned GUARD = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     wr_en,
  input logic                     rd_adv,
  input logic [$clog2(DEPTH)-1:0] rd_step,
  input logic                     rd_req,
  input logic                     rd_valid,
  input logic                     rd_clamp,
  input logic                     overlap,
  input logic [$clog2(DEPTH)-1:0] rd_addr,
  input logic [$clog2(DEPTH)-1:0] wr_ptr,
  input logic [$clog2(DEPTH)-1:0] rd_ptr
);
  localparam int unsigned   AW   = $clog2(DEPTH);
  localparam logic [AW-1:0] G_V  = AW'(GUARD);
  localparam logic [AW-1:0] G_P1 = AW'(GUARD + 1);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (wr_ptr == G_V && rd_ptr == '0 && !overlap && !rd_valid && !rd_clamp));

  assert_wr_step_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (wr_ptr == AW'($past(wr_ptr) + 1'b1)));

  assert_wr_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(wr_ptr));

  assert_legal_margin_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_clamp) |-> (AW'($past(wr_ptr) - rd_addr) > G_V));

  assert_clamp_target_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_clamp) |-> (rd_addr == AW'($past(wr_ptr) - G_P1)));

  assert_overlap_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    overlap |=> overlap);

  assert_overlap_set_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_clamp) |-> overlap);

  assert_resp_latency_R6: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid);

  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rd_valid);

  assert_adv_step_R7: assert property (@(posedge clk) disable iff (rst)
    rd_adv |=> (rd_ptr == AW'($past(rd_ptr) + $past(rd_step))));
endmodule

bind src_stereo_fifo src_stereo_fifo_chk #(.DEPTH(DEPTH), .GUARD(GUARD)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .rd_adv   (rd_adv),
  .rd_step  (rd_step),
  .rd_req   (rd_req),
  .rd_valid (rd_valid),
  .rd_clamp (rd_clamp),
  .overlap  (overlap),
  .rd_addr  (rd_addr),
  .wr_ptr   (wr_ptr),
  .rd_ptr   (rd_ptr)
);

// File: tb/test_src_stereo_fifo.sv
`timescale 1ns/1ps
module test_src_stereo_fifo;
  localparam int DEPTH = 512;
  localparam int DW    = 24;
  localparam int AW    = 9;
  localparam int TW    = 6;

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_ADV = 2'd2;
  // {op, arg[8:0], exp_addr[8:0], exp_clamp, exp_overlap, pad}
  localparam int NV = 12;
  localparam logic [31:0] VEC [NV] = '{
    {OP_ADV, 9'd16,  9'd0,  1'b0, 1'b0, 10'd0},
    {OP_RD,  9'd0,   9'd16, 1'b0, 1'b0, 10'd0},
    {OP_RD,  9'd23,  9'd39, 1'b0, 1'b0, 10'd0},
    {OP_WR,  9'd0,   9'd0,  1'b0, 1'b0, 10'd0},
    {OP_RD,  9'd24,  9'd40, 1'b0, 1'b0, 10'd0},
    {OP_ADV, 9'd30,  9'd0,  1'b0, 1'b0, 10'd0},
    {OP_RD,  9'd0,   9'd40, 1'b1, 1'b1, 10'd0},
    {OP_RD,  9'd5,   9'd40, 1'b1, 1'b1, 10'd0},
    {OP_WR,  9'd0,   9'd0,  1'b0, 1'b0, 10'd0},
    {OP_RD,  9'd63,  9'd41, 1'b1, 1'b1, 10'd0},
    {OP_ADV, 9'd500, 9'd0,  1'b0, 1'b0, 10'd0},
    {OP_RD,  9'd7,   9'd41, 1'b0, 1'b1, 10'd0}
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          wr_en;
  logic [DW-1:0] wr_left, wr_right;
  logic          rd_adv;
  logic [AW-1:0] rd_step;
  logic          rd_req;
  logic [TW-1:0] rd_tap;
  logic          rd_valid;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_left, rd_right;
  logic          rd_clamp;
  logic          overlap;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [DW-1:0] ml [DEPTH];
  logic [DW-1:0] mr [DEPTH];
  int m_wr = 16;
  int wseq = 0;

  always #2 clk = ~clk;

  src_stereo_fifo i_src_stereo_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_left(wr_left), .wr_right(wr_right),
    .rd_adv(rd_adv), .rd_step(rd_step), .rd_req(rd_req), .rd_tap(rd_tap),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_left(rd_left), .rd_right(rd_right),
    .rd_clamp(rd_clamp), .overlap(overlap)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // drive one cycle from a falling edge, return at the next falling edge
  task automatic cyc(input logic we, input logic re, input int tap, input logic adv, input int step);
    wr_en    = we;
    wr_left  = DW'(24'h100000 + wseq);
    wr_right = DW'(24'h800000 + wseq * 7);
    rd_req   = re;
    rd_tap   = TW'(tap);
    rd_adv   = adv;
    rd_step  = AW'(step);
    if (we) begin
      ml[m_wr] = wr_left;
      mr[m_wr] = wr_right;
      m_wr = (m_wr + 1) % DEPTH;
      wseq++;
    end
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_req = 1'b0; rd_adv = 1'b0;
  endtask

  task automatic chk_read(input string req, input int ea, input logic ec, input logic eo, input bit data);
    chk({req, " valid"},   32'(rd_valid), 32'd1);
    chk({req, " addr"},    32'(rd_addr),  32'(ea));
    chk({req, " clamp"},   32'(rd_clamp), 32'(ec));
    chk({req, " overlap"}, 32'(overlap),  32'(eo));
    if (data) begin
      chk({req, " left"},  32'(rd_left),  32'(ml[ea]));
      chk({req, " right"}, 32'(rd_right), 32'(mr[ea]));
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_wr = 16;
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; rd_req = 1'b0; rd_adv = 1'b0;
    wr_left = '0; wr_right = '0; rd_step = '0; rd_tap = '0;
    @(negedge clk);
    do_reset();
    chk("R1 overlap after reset", 32'(overlap), 32'd0);
    chk("R1 valid after reset",   32'(rd_valid), 32'd0);

    for (int i = 0; i < 40; i++) cyc(1'b1, 1'b0, 0, 1'b0, 0);   // wr 16..55

    // table: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      int arg;
      op  = VEC[i][31:30];
      arg = int'(VEC[i][29:21]);
      case (op)
        OP_WR: begin
          cyc(1'b1, 1'b0, 0, 1'b0, 0);
          chk("R6 no response after write", 32'(rd_valid), 32'd0);
        end
        OP_RD: begin
          cyc(1'b0, 1'b1, arg, 1'b0, 0);
          chk_read("R3/R4/R5/R6 vector", int'(VEC[i][20:12]), VEC[i][11], VEC[i][10], 1'b1);
        end
        default: cyc(1'b0, 1'b0, 0, 1'b1, arg);
      endcase
    end

    // R9: wr=58 rd=34 room=24, tap 8 with write: judged before write -> clamp to 41
    cyc(1'b1, 1'b1, 8, 1'b0, 0);
    chk_read("R9 read+write", 41, 1'b1, 1'b1, 1'b1);
    // R9: room=25, tap 8 with advance by 1: judged before advance -> legal 42
    cyc(1'b0, 1'b1, 8, 1'b1, 1);
    chk_read("R9 read+advance", 42, 1'b0, 1'b1, 1'b1);

    // R1: reset mid-run
    do_reset();
    chk("R1 overlap cleared", 32'(overlap), 32'd0);
    chk("R1 valid cleared",   32'(rd_valid), 32'd0);
    cyc(1'b0, 1'b1, 0, 1'b0, 0);
    chk_read("R1 first read clamps to 511", 511, 1'b1, 1'b1, 1'b0);

    // R8: wrap of both pointers and the tap address
    do_reset();
    for (int i = 0; i < 490; i++) cyc(1'b1, 1'b0, 0, 1'b0, 0);  // wr=506
    cyc(1'b0, 1'b0, 0, 1'b1, 480);                              // rd=480
    for (int i = 0; i < 10; i++) cyc(1'b1, 1'b0, 0, 1'b0, 0);   // wr=4
    cyc(1'b0, 1'b1, 19, 1'b0, 0);
    chk_read("R8 R3 legal after write wrap", 499, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, 0, 1'b0, 0);   // wr=24
    cyc(1'b0, 1'b0, 0, 1'b1, 25);                               // rd=505, room 31
    cyc(1'b0, 1'b1, 10, 1'b0, 0);
    chk_read("R8 tap address wraps", 3, 1'b0, 1'b0, 1'b1);
    cyc(1'b0, 1'b1, 14, 1'b0, 0);
    chk_read("R3 last legal tap", 7, 1'b0, 1'b0, 1'b1);
    cyc(1'b0, 1'b1, 15, 1'b0, 0);
    chk_read("R4 first guarded tap", 7, 1'b1, 1'b1, 1'b1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule